// File: doc/BRIEF.md
# Dual-Mode Zero-Substitution Line Encoder

This block sits between the terminal side of a transmit channel and its line driver. It turns transmit data into a pair of unipolar rails, a positive one and a negative one, so that the driver can send bipolar pulses. Each bit period carries at most one pulse. A binary one goes out as a pulse of alternating polarity (AMI). Long runs of zeros are replaced by codes that contain a deliberate bipolar violation. The run length is three zeros in the shorter-run mode, used for DS3 and STS-1 lines, and four zeros in the longer-run mode, used for E3 lines.

The terminal side can deliver single-rail NRZ data, which the block codes. It can instead deliver a dual-rail pair that is already coded, which the block forwards unchanged. A static bypass control switches substitution off so that single-rail data goes out as plain AMI. Every path has the same fixed delay. That delay equals the run length of the selected mode, so a code can be placed over zeros that are still inside the block.

Line mode, bypass and input format are static. They may change only while reset is held.

Top module: `zsub_line_encoder`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and in the first cycle after it, both rails are low. After reset the first pulse sent is positive, and the violation parity starts even, so a zero run that opens the stream becomes the code with a balancing pulse.
- R2: The two rails are never high in the same cycle. A plain zero sent outside a substitution code leaves both rails low.
- R3: In coded single-rail mode, successive data ones go out with alternating polarity.
- R4: With `line_e3` low, every run of three zeros is sent as 0-0-V when an odd number of pulses have gone out since the last violation, and as B-0-V when that number is even.
- R5: With `line_e3` high, every run of four zeros is sent as 0-0-0-V when the pulse count since the last violation is odd, and as B-0-0-V when it is even.
- R6: A balancing pulse B takes the polarity opposite to the pulse before it and counts as a pulse. A violation V repeats the polarity of the pulse before it and clears the pulse count.
- R7: A bit sampled at clock edge k appears on the rails right after edge k+N. N is 3 when `line_e3` is low and 4 when it is high. Before the first such edge after reset, the rails stay low.
- R8: With `code_bypass` high and single-rail input, ones go out as plain AMI and zero runs are never replaced.
- R9: With `rail_in_sel` high, the rails repeat `rail_p_in` and `rail_n_in` after the same delay of N cycles, with no substitution, in either line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| line_e3 | input | 1 | 1 selects four-zero substitution (E3); 0 selects three-zero substitution (DS3/STS-1) |
| code_bypass | input | 1 | 1 disables zero substitution |
| rail_in_sel | input | 1 | 1 selects the pre-coded dual-rail input; 0 selects single-rail data |
| nrz_data | input | 1 | Single-rail transmit data |
| rail_p_in | input | 1 | Pre-coded positive rail |
| rail_n_in | input | 1 | Pre-coded negative rail |
| line_p | output | 1 | Positive pulse rail to the line driver |
| line_n | output | 1 | Negative pulse rail to the line driver |

## Verification
Every rail value is due exactly N clock edges after its input bit is sampled, where N is 3 or 4 depending on the line mode. A code that covers a zero run changes rail values that belong to earlier bits, but those values are still due at their own N-edge slots. Each scenario releases reset on the same falling edge that drives the first bit, and then samples the rails on every falling edge. The sample taken at step j+N+1 is compared with the expected value for bit j, which a sequential reference model computes from the requirements. The samples taken before that step must all be low.

// File: rtl/zsub_pkg.sv
package zsub_pkg;

   // Symbol kinds held in the coding window
   typedef enum logic [2:0] {
      SK_FILL  = 3'd0,   // zero already consumed (reset or inside a code)
      SK_SPACE = 3'd1,   // plain data zero, still eligible for substitution
      SK_MARK  = 3'd2,   // data one
      SK_BAL   = 3'd3,   // balancing pulse of a substitution code
      SK_VIOL  = 3'd4,   // violation pulse of a substitution code
      SK_RAW   = 3'd5    // pre-coded dual-rail symbol
   } sym_kind_e;

   typedef struct packed {
      sym_kind_e kind;
      logic      rp;
      logic      rn;
   } slot_t;

   localparam slot_t SLOT_IDLE = '{kind: SK_FILL, rp: 1'b0, rn: 1'b0};

   function automatic logic alternating_kind(sym_kind_e k);
      return (k == SK_MARK) || (k == SK_BAL);
   endfunction

endpackage

// File: rtl/zsub_front.sv
module zsub_front
   import zsub_pkg::*;
(
   input  logic  dual_sel,
   input  logic  nrz_d,
   input  logic  rail_p,
   input  logic  rail_n,
   output slot_t sym_o
);

   always_comb begin
      sym_o = SLOT_IDLE;
      if (dual_sel) begin
         sym_o.kind = SK_RAW;
         sym_o.rp   = rail_p;
         sym_o.rn   = rail_n;
      end else begin
         sym_o.kind = nrz_d ? SK_MARK : SK_SPACE;
      end
   end

endmodule

// File: rtl/zsub_window.sv
module zsub_window
   import zsub_pkg::*;
#(
   parameter int RUN_SHORT = 3,
   parameter int RUN_LONG  = 4
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  long_sel,
   input  logic  subst_off,
   input  slot_t sym_in,
   input  logic  odd_after,
   output slot_t leave_o
);

   localparam int DEPTH = RUN_LONG;

   slot_t                slot_q [DEPTH];
   slot_t                slot_d [DEPTH];
   logic [DEPTH-2:0]     plain;
   logic                 older_plain;
   logic                 fire;
   int                   n_act;

   assign n_act = long_sel ? RUN_LONG : RUN_SHORT;

   generate
      for (genvar gi = 0; gi < DEPTH - 1; gi++) begin : g_plain
         assign plain[gi] = (slot_q[gi].kind == SK_SPACE);
      end
   endgenerate

   // the N-1 newest held slots must all be untouched zeros
   always_comb begin
      older_plain = 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
         if (i + 1 < n_act) older_plain = older_plain & plain[i];
      end
   end

   assign fire = !subst_off && (sym_in.kind == SK_SPACE) && older_plain;

   // oldest active slot leaves toward the polarity stage
   always_comb begin
      leave_o = SLOT_IDLE;
      for (int i = 0; i < DEPTH; i++) begin
         if (i + 1 == n_act) leave_o = slot_q[i];
      end
   end

   // shift, then overwrite the window with a substitution code
   always_comb begin
      slot_d[0] = sym_in;
      for (int i = 1; i < DEPTH; i++) slot_d[i] = slot_q[i-1];
      if (fire) begin
         slot_d[0].kind = SK_VIOL;
         for (int i = 1; i < DEPTH; i++) begin
            if (i < n_act) begin
               if ((i + 1 == n_act) && !odd_after) slot_d[i].kind = SK_BAL;
               else                                 slot_d[i].kind = SK_FILL;
            end
         end
      end
   end

   generate
      for (genvar gs = 0; gs < DEPTH; gs++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst) slot_q[gs] <= SLOT_IDLE;
            else     slot_q[gs] <= slot_d[gs];
         end
      end
   endgenerate

endmodule

// File: rtl/zsub_polarity.sv
module zsub_polarity
   import zsub_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  slot_t leave_i,
   output logic  odd_after_o,
   output logic  tx_pos_o,
   output logic  tx_neg_o
);

   logic last_pos_q, last_pos_d;
   logic odd_q, odd_d;
   logic pos_d, neg_d;

   always_comb begin
      last_pos_d = last_pos_q;
      odd_d      = odd_q;
      pos_d      = 1'b0;
      neg_d      = 1'b0;
      if (alternating_kind(leave_i.kind)) begin
         pos_d      = ~last_pos_q;
         neg_d      = last_pos_q;
         last_pos_d = ~last_pos_q;
         odd_d      = ~odd_q;
      end else if (leave_i.kind == SK_VIOL) begin
         pos_d = last_pos_q;
         neg_d = ~last_pos_q;
         odd_d = 1'b0;
      end else if (leave_i.kind == SK_RAW) begin
         pos_d = leave_i.rp;
         neg_d = leave_i.rn & ~leave_i.rp;
      end
   end

   assign odd_after_o = odd_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         last_pos_q <= 1'b0;
         odd_q      <= 1'b0;
         tx_pos_o   <= 1'b0;
         tx_neg_o   <= 1'b0;
      end else begin
         last_pos_q <= last_pos_d;
         odd_q      <= odd_d;
         tx_pos_o   <= pos_d;
         tx_neg_o   <= neg_d;
      end
   end

   // R2
   rails_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(tx_pos_o && tx_neg_o));

endmodule

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder
   import zsub_pkg::*;
#(
   parameter int RUN_B3ZS = 3,
   parameter int RUN_HDB3 = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic line_e3,
   input  logic code_bypass,
   input  logic rail_in_sel,
   input  logic nrz_data,
   input  logic rail_p_in,
   input  logic rail_n_in,
   output logic line_p,
   output logic line_n
);

   localparam int WARM_MAX = RUN_HDB3 + 1;
   localparam int CW       = $clog2(WARM_MAX + 1);

   generate
      if (RUN_B3ZS < 2 || RUN_HDB3 <= RUN_B3ZS || RUN_HDB3 > 8) begin : g_bad_runs
         $error("zsub_line_encoder: run lengths out of range");
      end
   endgenerate

   slot_t sym_in;
   slot_t leave;
   logic  odd_after;

   zsub_front u_front (
      .dual_sel (rail_in_sel),
      .nrz_d    (nrz_data),
      .rail_p   (rail_p_in),
      .rail_n   (rail_n_in),
      .sym_o    (sym_in)
   );

   zsub_window #(
      .RUN_SHORT (RUN_B3ZS),
      .RUN_LONG  (RUN_HDB3)
   ) u_window (
      .clk       (clk),
      .rst       (rst),
      .long_sel  (line_e3),
      .subst_off (code_bypass),
      .sym_in    (sym_in),
      .odd_after (odd_after),
      .leave_o   (leave)
   );

   zsub_polarity u_pol (
      .clk         (clk),
      .rst         (rst),
      .leave_i     (leave),
      .odd_after_o (odd_after),
      .tx_pos_o    (line_p),
      .tx_neg_o    (line_n)
   );

   // ---- observation state for the assertions below ----
   logic [CW-1:0] warm_q;
   logic [CW-1:0] gap_q;
   logic          seen_q;
   logic          last_pulse_q;
   logic          rst_q;
   logic          pulse;
   int            n_act;

   assign pulse = line_p | line_n;
   assign n_act = line_e3 ? RUN_HDB3 : RUN_B3ZS;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         warm_q       <= '0;
         gap_q        <= '0;
         seen_q       <= 1'b0;
         last_pulse_q <= 1'b0;
      end else begin
         if (warm_q != CW'(WARM_MAX)) warm_q <= warm_q + 1'b1;
         if (pulse) begin
            gap_q        <= '0;
            seen_q       <= 1'b1;
            last_pulse_q <= line_p;
         end else if (gap_q != CW'(WARM_MAX)) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (!line_p && !line_n));

   // R9
   dual_short_chk: assert property (@(posedge clk) disable iff (rst)
      (rail_in_sel && !line_e3 && warm_q >= CW'(RUN_B3ZS + 1)) |->
      (line_p == $past(rail_p_in, RUN_B3ZS + 1) && line_n == $past(rail_n_in, RUN_B3ZS + 1)));

   // R9
   dual_long_chk: assert property (@(posedge clk) disable iff (rst)
      (rail_in_sel && line_e3 && warm_q >= CW'(RUN_HDB3 + 1)) |->
      (line_p == $past(rail_p_in, RUN_HDB3 + 1) && line_n == $past(rail_n_in, RUN_HDB3 + 1)));

   // R8
   ami_bypass_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && code_bypass && !rail_in_sel && pulse) |-> (line_p != last_pulse_q));

   // R4 R5
   run_limit_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && !code_bypass && !rail_in_sel) |-> (int'(gap_q) < n_act));

endmodule

// File: tb/sim_zsub_line_encoder.sv
module sim_zsub_line_encoder;

   localparam int MAXLEN = 96;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic line_e3 = 1'b0;
   logic code_bypass = 1'b0;
   logic rail_in_sel = 1'b0;
   logic nrz_data = 1'b0;
   logic rail_p_in = 1'b0;
   logic rail_n_in = 1'b0;
   logic line_p, line_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   bit stim_d [MAXLEN];
   bit stim_p [MAXLEN];
   bit stim_n [MAXLEN];
   bit exp_p  [MAXLEN];
   bit exp_n  [MAXLEN];
   bit raw_p  [MAXLEN];
   bit raw_n  [MAXLEN];
   int stim_len;

   always #5 clk = ~clk;

   zsub_line_encoder u0 (
      .clk(clk), .rst(rst), .line_e3(line_e3), .code_bypass(code_bypass),
      .rail_in_sel(rail_in_sel), .nrz_data(nrz_data), .rail_p_in(rail_p_in),
      .rail_n_in(rail_n_in), .line_p(line_p), .line_n(line_n)
   );

   task automatic check2(input string tag, input int idx, input bit gp, input bit gn,
                         input bit ep, input bit en);
      n_cmp++;
      if (gp !== ep || gn !== en) begin
         n_bad++;
         $display("FAIL %s bit %0d: got p=%0b n=%0b expected p=%0b n=%0b",
                  tag, idx, gp, gn, ep, en);
      end
   endtask

   // '1'/'0' single-rail bits, 'p'/'n'/'0' dual-rail symbols
   task automatic load(input string s);
      for (int i = 0; i < MAXLEN; i++) begin
         stim_d[i] = 0; stim_p[i] = 0; stim_n[i] = 0;
      end
      for (int i = 0; i < s.len(); i++) begin
         stim_d[i] = (s[i] == "1");
         stim_p[i] = (s[i] == "p");
         stim_n[i] = (s[i] == "n");
      end
      stim_len = s.len();
   endtask

   // reference model from the requirements
   task automatic model(input bit e3, input bit byp, input bit dual, input int total);
      int  n   = e3 ? 4 : 3;
      bit  lastpos = 0;
      int  cnt = 0;
      int  z   = 0;
      for (int i = 0; i < total; i++) begin
         exp_p[i] = 0; exp_n[i] = 0;
         if (dual) begin
            exp_p[i] = stim_p[i]; exp_n[i] = stim_n[i];
         end else if (stim_d[i]) begin
            lastpos = !lastpos;
            exp_p[i] = lastpos; exp_n[i] = !lastpos;
            cnt++; z = 0;
         end else if (!byp) begin
            z++;
            if (z == n) begin
               if (cnt % 2 == 0) begin
                  lastpos = !lastpos;
                  exp_p[i-n+1] = lastpos; exp_n[i-n+1] = !lastpos;
               end
               exp_p[i] = lastpos; exp_n[i] = !lastpos;
               cnt = 0; z = 0;
            end
         end
      end
   endtask

   task automatic run_case(input string tag, input bit e3, input bit byp, input bit dual,
                           input string s);
      int n = e3 ? 4 : 3;
      int total;
      load(s);
      total = stim_len + n + 1;
      @(negedge clk);
      rst = 1; line_e3 = e3; code_bypass = byp; rail_in_sel = dual;
      nrz_data = 0; rail_p_in = 0; rail_n_in = 0;
      repeat (3) @(negedge clk);
      check2("R1 reset idle", -1, line_p, line_n, 0, 0);
      for (int st = 0; st < total; st++) begin
         if (st > 0) @(negedge clk);
         if (st == 0) rst = 0;
         raw_p[st] = line_p; raw_n[st] = line_n;
         nrz_data  = stim_d[st];
         rail_p_in = stim_p[st];
         rail_n_in = stim_n[st];
      end
      model(e3, byp, dual, total);
      for (int st = 0; st <= n; st++)
         check2("R7 quiet before latency", st, raw_p[st], raw_n[st], 0, 0);
      for (int j = 0; j < stim_len; j++) begin
         check2(tag, j, raw_p[j+n+1], raw_n[j+n+1], exp_p[j], exp_n[j]);
         n_cmp++;
         if (raw_p[j+n+1] && raw_n[j+n+1]) begin
            n_bad++;
            $display("FAIL R2 bit %0d: got p=1 n=1 expected at most one rail", j);
         end
      end
   endtask

   task automatic t_short_ami();   run_case("R3 R7", 0, 0, 0, "1101101110111");      endtask
   task automatic t_short_runs();  run_case("R4 R6", 0, 0, 0, "1000110000001010001001000000000"); endtask
   task automatic t_long_ami();    run_case("R3", 1, 0, 0, "11011101");               endtask
   task automatic t_long_runs();   run_case("R5 R6", 1, 0, 0, "10000110000000010000011000000000001"); endtask
   task automatic t_reset_even();
      run_case("R1", 1, 0, 0, "000000001");
      run_case("R1", 0, 0, 0, "0001");
   endtask
   task automatic t_bypass();
      run_case("R8", 0, 1, 0, "1000010000001100000");
      run_case("R8", 1, 1, 0, "100000000101");
   endtask
   task automatic t_dual();
      run_case("R9", 0, 0, 1, "p00n000pn0000p");
      run_case("R9", 1, 1, 1, "n0000p00000np0");
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_short_ami();
      t_short_runs();
      t_long_ami();
      t_long_runs();
      t_reset_even();
      t_bypass();
      t_dual();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule